// File: doc/BRIEF.md
# Programmable LCD panel timing generator

The block generates the raster timing for a parallel RGB panel: horizontal and vertical sync pulses, a data-enable window and the current pixel and line position. Sync widths, active-window edges and frame totals come from programmed values held outside the block. Scanning advances only on cycles where the pixel-clock enable is high, so the block runs on the system clock while stepping at pixel rate.

Software starts scanning with a control write and stops it with a second control write. A stop request lets the current frame finish, then parks every output at its inactive level and raises a stopped status that must be cleared before the next start. Single-cycle start-of-frame and end-of-frame events feed two sticky interrupt flags, each gated by its own enable.

Top module: `lcd_timing_gen`

## Requirements
- R1: Both position counters are 0 at the leading edge of sync; hsync is active while running and the pixel position is below `hsync_len_i` (10 bits). A length of 0 gives no pulse.
- R2: The pixel position counts pixel-clock enables from 0 to (horizontal total - 1) then returns to 0; the line position steps on each such wrap and returns to 0 after (vertical total - 1). The horizontal total is `total_i[31:16]`, the vertical total `total_i[15:0]`; each total is at least 2.
- R3: vsync is active while running and the line position is below `vsync_len_i` (10 bits).
- R4: Data enable is active while running, start <= pixel position < end and start <= line position < end, where `hact_i`/`vact_i` hold the start in bits 31:16 and the end in bits 15:0.
- R5: `pol_i` bit 3 makes hsync active low, bit 0 vsync, bit 1 data enable; `pclk_fall_o` follows `pol_i` bit 2 (data launched on the falling pixel-clock edge when 1).
- R6: A control write with start=1, stop=0 while stopped and with the stopped status clear begins scanning at position (0,0) from the next cycle; positions hold on cycles without a pixel-clock enable.
- R7: A control write with stop=1 while running lets the frame finish; on its last pixel tick scanning halts, positions return to 0, all outputs go inactive and `disabled_o` rises. A stop write while already halted raises `disabled_o` on the next cycle. Stop wins over start in the same write.
- R8: While `disabled_o` is 1 a start write is ignored; `status_clr_i` clears `disabled_o` (a simultaneous set wins).
- R9: `sof_o` is high for the pixel tick at position (0,0) while running and `eof_o` for the tick at the last pixel of the last line.
- R10: `irq_flags_o` bit 0 latches `sof_o` when the start-of-frame enable is set and bit 1 latches `eof_o` when the end-of-frame enable is set; both enables are loaded on every control write, flags clear by writing 1 on `irq_clr_i` (a set in the same cycle wins), and `irq_o` is their OR.
- R11: After reset the block is halted with positions 0, outputs at inactive level, flags, enables and `disabled_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_en_i | input | 1 | Pixel-clock enable |
| pol_i | input | 4 | Polarity and launch-edge configuration |
| hsync_len_i | input | 10 | Horizontal sync width in pixels |
| vsync_len_i | input | 10 | Vertical sync width in lines |
| total_i | input | 32 | Horizontal total (31:16), vertical total (15:0) |
| hact_i | input | 32 | Horizontal active start (31:16), end (15:0) |
| vact_i | input | 32 | Vertical active start (31:16), end (15:0) |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_start_i | input | 1 | Control write: start scanning |
| ctrl_stop_i | input | 1 | Control write: stop at end of frame |
| ctrl_sof_ie_i | input | 1 | Control write: start-of-frame interrupt enable |
| ctrl_eof_ie_i | input | 1 | Control write: end-of-frame interrupt enable |
| status_clr_i | input | 1 | Clear the stopped status |
| irq_clr_i | input | 2 | Write-1-to-clear for the interrupt flags |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data enable |
| pclk_fall_o | output | 1 | Launch data on falling pixel-clock edge |
| hpos_o | output | 16 | Pixel position within the line |
| vpos_o | output | 16 | Line position within the frame |
| sof_o | output | 1 | Start-of-frame event |
| eof_o | output | 1 | End-of-frame event |
| irq_flags_o | output | 2 | Sticky flags: bit 0 start, bit 1 end of frame |
| irq_o | output | 1 | Any flag set |
| disabled_o | output | 1 | Scanning has stopped |

## Verification
Positions, syncs and data enable change one rising edge after the pixel tick or control write that moves them, and `disabled_o` and the interrupt flags one edge after the event or write that sets them; `sof_o` and `eof_o` are combinational and valid in the tick cycle itself. The bench keeps a cycle model that it advances at every rising edge from the inputs it applied, and compares all outputs at the following falling edge, so each result is checked exactly in the cycle it is due. Random pixel enables, interrupt-enable writes and flag clears run over several randomly sized rasters, with directed cases for reset, a held enable, a stop while halted and a start blocked by the stopped status.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int unsigned AXIS_N = 2;
  localparam int unsigned AX_H   = 0;
  localparam int unsigned AX_V   = 1;
  // pol_i bit positions
  localparam int unsigned POL_VS_LOW = 0;
  localparam int unsigned POL_DE_LOW = 1;
  localparam int unsigned POL_FALL   = 2;
  localparam int unsigned POL_HS_LOW = 3;
  localparam int unsigned POL_W      = 4;
  // irq flag bit positions
  localparam int unsigned IRQ_SOF = 0;
  localparam int unsigned IRQ_EOF = 1;
  localparam int unsigned IRQ_N   = 2;
endpackage

// File: rtl/lcd_tg_axis.sv
module lcd_tg_axis #(
  parameter int unsigned POS_W  = 16,
  parameter int unsigned SYNC_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [POS_W-1:0]  total_i,
  input  logic [SYNC_W-1:0] sync_len_i,
  input  logic [POS_W-1:0]  win_start_i,
  input  logic [POS_W-1:0]  win_end_i,
  output logic [POS_W-1:0]  cnt_o,
  output logic              last_o,
  output logic              sync_act_o,
  output logic              win_act_o
);
  logic [POS_W-1:0] cnt_q;

  assign last_o = (cnt_q == total_i - POS_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= last_o ? '0 : cnt_q + POS_W'(1);
  end

  assign cnt_o      = cnt_q;
  assign sync_act_o = (cnt_q < POS_W'(sync_len_i));
  assign win_act_o  = (cnt_q >= win_start_i) && (cnt_q < win_end_i);
endmodule

// File: rtl/lcd_tg_ctrl.sv
module lcd_tg_ctrl
  import lcd_tg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pix_en_i,
  input  logic             frame_first_i,
  input  logic             frame_last_i,
  input  logic             ctrl_we_i,
  input  logic             ctrl_start_i,
  input  logic             ctrl_stop_i,
  input  logic             ctrl_sof_ie_i,
  input  logic             ctrl_eof_ie_i,
  input  logic             status_clr_i,
  input  logic [IRQ_N-1:0] irq_clr_i,
  output logic             run_o,
  output logic             tick_o,
  output logic             sof_o,
  output logic             eof_o,
  output logic [IRQ_N-1:0] irq_flags_o,
  output logic             disabled_o
);
  logic             run_q, pend_q, dis_q;
  logic [IRQ_N-1:0] ie_q, flags_q, evt;
  logic             halt, dis_set, start;

  assign tick_o = pix_en_i && run_q;
  assign sof_o  = tick_o && frame_first_i;
  assign eof_o  = tick_o && frame_last_i;

  assign halt    = eof_o && pend_q;
  assign dis_set = halt || (!run_q && ctrl_we_i && ctrl_stop_i);
  assign start   = !run_q && !dis_q && ctrl_we_i && ctrl_start_i && !ctrl_stop_i;

  always_comb begin
    evt          = '0;
    evt[IRQ_SOF] = sof_o && ie_q[IRQ_SOF];
    evt[IRQ_EOF] = eof_o && ie_q[IRQ_EOF];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      pend_q  <= 1'b0;
      dis_q   <= 1'b0;
      ie_q    <= '0;
      flags_q <= '0;
    end else begin
      if (ctrl_we_i) begin
        ie_q[IRQ_SOF] <= ctrl_sof_ie_i;
        ie_q[IRQ_EOF] <= ctrl_eof_ie_i;
      end
      flags_q <= (flags_q & ~irq_clr_i) | evt;
      if (halt) begin
        run_q  <= 1'b0;
        pend_q <= 1'b0;
      end else if (run_q && ctrl_we_i && ctrl_stop_i) begin
        pend_q <= 1'b1;
      end else if (start) begin
        run_q <= 1'b1;
      end
      if (dis_set)           dis_q <= 1'b1;
      else if (status_clr_i) dis_q <= 1'b0;
    end
  end

  assign run_o       = run_q;
  assign irq_flags_o = flags_q;
  assign disabled_o  = dis_q;
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int unsigned POS_W  = 16,
  parameter int unsigned SYNC_W = 10,
  localparam int unsigned WORD_W = 2 * POS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_en_i,
  input  logic [POL_W-1:0]  pol_i,
  input  logic [SYNC_W-1:0] hsync_len_i,
  input  logic [SYNC_W-1:0] vsync_len_i,
  input  logic [WORD_W-1:0] total_i,
  input  logic [WORD_W-1:0] hact_i,
  input  logic [WORD_W-1:0] vact_i,
  input  logic              ctrl_we_i,
  input  logic              ctrl_start_i,
  input  logic              ctrl_stop_i,
  input  logic              ctrl_sof_ie_i,
  input  logic              ctrl_eof_ie_i,
  input  logic              status_clr_i,
  input  logic [IRQ_N-1:0]  irq_clr_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              pclk_fall_o,
  output logic [POS_W-1:0]  hpos_o,
  output logic [POS_W-1:0]  vpos_o,
  output logic              sof_o,
  output logic              eof_o,
  output logic [IRQ_N-1:0]  irq_flags_o,
  output logic              irq_o,
  output logic              disabled_o
);
  logic [AXIS_N-1:0][POS_W-1:0]  cnt, tot, w_st, w_en;
  logic [AXIS_N-1:0][SYNC_W-1:0] slen;
  logic [AXIS_N-1:0]             last, s_act, w_act, step;
  logic                          run, tick;

  // upper half of each packed word is horizontal / start, lower half vertical / end
  assign tot[AX_H]  = total_i[WORD_W-1:POS_W];
  assign tot[AX_V]  = total_i[POS_W-1:0];
  assign w_st[AX_H] = hact_i[WORD_W-1:POS_W];
  assign w_en[AX_H] = hact_i[POS_W-1:0];
  assign w_st[AX_V] = vact_i[WORD_W-1:POS_W];
  assign w_en[AX_V] = vact_i[POS_W-1:0];
  assign slen[AX_H] = hsync_len_i;
  assign slen[AX_V] = vsync_len_i;

  assign step[AX_H] = tick;
  assign step[AX_V] = tick && last[AX_H];

  for (genvar a = 0; a < AXIS_N; a++) begin : g_axis
    lcd_tg_axis #(.POS_W(POS_W), .SYNC_W(SYNC_W)) u_axis (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .step_i      (step[a]),
      .total_i     (tot[a]),
      .sync_len_i  (slen[a]),
      .win_start_i (w_st[a]),
      .win_end_i   (w_en[a]),
      .cnt_o       (cnt[a]),
      .last_o      (last[a]),
      .sync_act_o  (s_act[a]),
      .win_act_o   (w_act[a])
    );
  end

  lcd_tg_ctrl u_ctrl (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .pix_en_i      (pix_en_i),
    .frame_first_i ((cnt[AX_H] == '0) && (cnt[AX_V] == '0)),
    .frame_last_i  (&last),
    .ctrl_we_i     (ctrl_we_i),
    .ctrl_start_i  (ctrl_start_i),
    .ctrl_stop_i   (ctrl_stop_i),
    .ctrl_sof_ie_i (ctrl_sof_ie_i),
    .ctrl_eof_ie_i (ctrl_eof_ie_i),
    .status_clr_i  (status_clr_i),
    .irq_clr_i     (irq_clr_i),
    .run_o         (run),
    .tick_o        (tick),
    .sof_o         (sof_o),
    .eof_o         (eof_o),
    .irq_flags_o   (irq_flags_o),
    .disabled_o    (disabled_o)
  );

  assign hsync_o     = (run && s_act[AX_H]) ^ pol_i[POL_HS_LOW];
  assign vsync_o     = (run && s_act[AX_V]) ^ pol_i[POL_VS_LOW];
  assign de_o        = (run && (&w_act)) ^ pol_i[POL_DE_LOW];
  assign pclk_fall_o = pol_i[POL_FALL];
  assign hpos_o      = cnt[AX_H];
  assign vpos_o      = cnt[AX_V];
  assign irq_o       = |irq_flags_o;
endmodule

// File: rtl/lcd_tg_checker.sv
module lcd_tg_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        pix_en_i,
  input logic [3:0]  pol_i,
  input logic [31:0] total_i,
  input logic [1:0]  irq_clr_i,
  input logic        hsync_o,
  input logic        vsync_o,
  input logic        de_o,
  input logic [15:0] hpos_o,
  input logic [15:0] vpos_o,
  input logic        sof_o,
  input logic        eof_o,
  input logic [1:0]  irq_flags_o,
  input logic        disabled_o
);
  p_hwrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_en_i && !eof_o && hpos_o == total_i[31:16] - 16'd1) |=> (hpos_o == 16'd0));

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pix_en_i |=> ($stable(hpos_o) && $stable(vpos_o)));

  p_frame_end_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eof_o |=> (hpos_o == 16'd0 && vpos_o == 16'd0));

  p_idle_levels_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disabled_o |-> (hsync_o == pol_i[3] && vsync_o == pol_i[0] && de_o == pol_i[1]));

  p_sof_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |=> !sof_o);

  p_sof_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flags_o[0] && !irq_clr_i[0]) |=> irq_flags_o[0]);

  p_eof_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flags_o[1] && !irq_clr_i[1]) |=> irq_flags_o[1]);
endmodule

bind lcd_timing_gen lcd_tg_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pix_en_i    (pix_en_i),
  .pol_i       (pol_i),
  .total_i     (total_i),
  .irq_clr_i   (irq_clr_i),
  .hsync_o     (hsync_o),
  .vsync_o     (vsync_o),
  .de_o        (de_o),
  .hpos_o      (hpos_o),
  .vpos_o      (vpos_o),
  .sof_o       (sof_o),
  .eof_o       (eof_o),
  .irq_flags_o (irq_flags_o),
  .disabled_o  (disabled_o)
);

// File: tb/lcd_timing_gen_tb_top.sv
module lcd_timing_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_en = 1'b0;
  logic [3:0]  pol = 4'h0;
  logic [9:0]  hlen = 10'd2, vlen = 10'd1;
  logic [31:0] total_w = {16'd8, 16'd6};
  logic [31:0] hact_w = {16'd3, 16'd6};
  logic [31:0] vact_w = {16'd2, 16'd5};
  logic        we = 1'b0, c_start = 1'b0, c_stop = 1'b0, c_sie = 1'b0, c_eie = 1'b0;
  logic        sclr = 1'b0;
  logic [1:0]  iclr = 2'b00;

  logic        hsync, vsync, de, pfall, sof, eof, irq, dis;
  logic [15:0] hpos, vpos;
  logic [1:0]  flags;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  int unsigned seed = 32'd2024;

  // reference model state
  int   m_h, m_v;
  logic m_run, m_pend, m_dis;
  logic [1:0] m_ie, m_flags;

  always #10 clk = ~clk;

  lcd_timing_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pix_en_i(pix_en), .pol_i(pol),
    .hsync_len_i(hlen), .vsync_len_i(vlen), .total_i(total_w),
    .hact_i(hact_w), .vact_i(vact_w), .ctrl_we_i(we),
    .ctrl_start_i(c_start), .ctrl_stop_i(c_stop),
    .ctrl_sof_ie_i(c_sie), .ctrl_eof_ie_i(c_eie),
    .status_clr_i(sclr), .irq_clr_i(iclr),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .pclk_fall_o(pfall),
    .hpos_o(hpos), .vpos_o(vpos), .sof_o(sof), .eof_o(eof),
    .irq_flags_o(flags), .irq_o(irq), .disabled_o(dis)
  );

  function automatic int ht(); return int'(total_w[31:16]); endfunction
  function automatic int vt(); return int'(total_w[15:0]);  endfunction
  function automatic logic m_tick(); return pix_en && m_run; endfunction
  function automatic logic e_sof(); return m_tick() && m_h == 0 && m_v == 0; endfunction
  function automatic logic e_eof(); return m_tick() && m_h == ht() - 1 && m_v == vt() - 1; endfunction
  function automatic logic e_hs(); return (m_run && m_h < int'(hlen)) ^ pol[3]; endfunction
  function automatic logic e_vs(); return (m_run && m_v < int'(vlen)) ^ pol[0]; endfunction
  function automatic logic e_de();
    return (m_run && m_h >= int'(hact_w[31:16]) && m_h < int'(hact_w[15:0]) &&
            m_v >= int'(vact_w[31:16]) && m_v < int'(vact_w[15:0])) ^ pol[1];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_h = 0; m_v = 0; m_run = 0; m_pend = 0; m_dis = 0; m_ie = 0; m_flags = 0;
    end else begin
      logic s_t, e_t, dset;
      logic [1:0] nf;
      int nh, nv;
      s_t = e_sof(); e_t = e_eof();
      nf = (m_flags & ~iclr) | {e_t & m_ie[1], s_t & m_ie[0]};
      nh = m_h; nv = m_v;
      if (m_tick()) begin
        if (m_h == ht() - 1) begin
          nh = 0;
          nv = (m_v == vt() - 1) ? 0 : m_v + 1;
        end else nh = m_h + 1;
      end
      dset = 0;
      if (m_run) begin
        if (e_t && m_pend) begin m_run = 0; m_pend = 0; dset = 1; end
        else if (we && c_stop) m_pend = 1;
      end else begin
        if (we && c_stop) dset = 1;
        else if (we && c_start && !m_dis) m_run = 1;
      end
      if (dset) m_dis = 1; else if (sclr) m_dis = 0;
      if (we) m_ie = {c_eie, c_sie};
      m_flags = nf; m_h = nh; m_v = nv;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic compare_all();
    chk("R2 hpos", int'(hpos), m_h);
    chk("R2 vpos", int'(vpos), m_v);
    chk("R1 hsync", int'(hsync), int'(e_hs()));
    chk("R3 vsync", int'(vsync), int'(e_vs()));
    chk("R4 de", int'(de), int'(e_de()));
    chk("R5 pclk_fall", int'(pfall), int'(pol[2]));
    chk("R9 sof", int'(sof), int'(e_sof()));
    chk("R9 eof", int'(eof), int'(e_eof()));
    chk("R10 flags", int'(flags), int'(m_flags));
    chk("R10 irq", int'(irq), int'(|m_flags));
    chk("R7 disabled", int'(dis), int'(m_dis));
  endtask

  // compare at falling edge, then set inputs for the next rising edge
  task automatic step(input logic pe, input logic w, input logic st, input logic sp,
                      input logic si, input logic ei, input logic sc, input logic [1:0] ic);
    @(negedge clk);
    compare_all();
    pix_en = pe; we = w; c_start = st; c_stop = sp; c_sie = si; c_eie = ei;
    sclr = sc; iclr = ic;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 0, 0, 0, 0, 0, 0, 2'b00);
  endtask

  task automatic rnd_cfg();
    int hs, he, vs, ve;
    hlen = 10'($urandom_range(0, 3));
    vlen = 10'($urandom_range(0, 2));
    hs = int'(hlen) + $urandom_range(0, 3);
    he = hs + $urandom_range(0, 6);
    vs = int'(vlen) + $urandom_range(0, 2);
    ve = vs + $urandom_range(0, 4);
    hact_w = {16'(hs), 16'(he)};
    vact_w = {16'(vs), 16'(ve)};
    total_w = {16'(he + $urandom_range(1, 3)), 16'(ve + $urandom_range(1, 2))};
    if (total_w[31:16] < 16'd2) total_w[31:16] = 16'd2;
    if (total_w[15:0] < 16'd2) total_w[15:0] = 16'd2;
    pol = 4'($urandom_range(0, 15));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 hpos", int'(hpos), 0);
    chk("R11 hsync idle", int'(hsync), 0);
    chk("R11 disabled", int'(dis), 0);
    chk("R11 flags", int'(flags), 0);
    rst_n = 1'b1;
    idle(2);

    // R6: start with pixel enable low holds position at 0
    step(1'b0, 1, 1, 0, 1, 1, 0, 2'b00);
    for (int i = 0; i < 3; i++) step(1'b0, 0, 0, 0, 0, 0, 0, 2'b00);
    chk("R6 held hpos", int'(hpos), 0);
    chk("R6 running hsync", int'(hsync), 1);
    idle(3 * 48);
    // R7: stop after frame end
    step(1'b1, 1, 0, 1, 1, 1, 0, 2'b00);
    for (int i = 0; i < 200 && !dis; i++) idle(1);
    chk("R7 stopped", int'(dis), 1);
    chk("R7 vpos", int'(vpos), 0);

    // R8: start ignored while status set, works after clear
    step(1'b1, 1, 1, 0, 0, 0, 0, 2'b00);
    idle(3);
    chk("R8 still halted", int'(hpos), 0);
    chk("R8 status held", int'(dis), 1);
    step(1'b1, 0, 0, 0, 0, 0, 1, 2'b00);
    idle(1);
    chk("R8 status cleared", int'(dis), 0);
    // R7: stop while halted sets status next cycle, stop wins over start
    step(1'b1, 1, 1, 1, 0, 0, 0, 2'b00);
    idle(1);
    chk("R7 halted stop", int'(dis), 1);
    chk("R7 stop wins", int'(hpos), 0);

    for (int ph = 0; ph < 8; ph++) begin
      step(1'b1, 0, 0, 0, 0, 0, 1, 2'b11);
      rnd_cfg();
      idle(2);
      step(1'b1, 1, 1, 0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0, 2'b00);
      for (int i = 0; i < 4 * ht() * vt() + 20; i++) begin
        logic w;
        w = ($urandom_range(0, 19) == 0);
        step(($urandom_range(0, 3) != 0), w, 1'($urandom_range(0, 1)), 1'b0,
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 0,
             ($urandom_range(0, 9) == 0) ? 2'($urandom_range(1, 3)) : 2'b00);
      end
      step(1'b1, 1, 0, 1, 1, 1, 0, 2'b00);
      for (int i = 0; i < 4000 && !dis; i++)
        step(($urandom_range(0, 3) != 0), 0, 0, 0, 0, 0, 0, 2'b00);
      chk("R7 phase stop", int'(dis), 1);
    end

    idle(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule